// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital control wrapped around a successive-approximation converter. Software sees one 8-bit control register. Through it, software enables the converter, picks a tracking style, and chooses which event starts a conversion. The start event can be a software write, either of two timer-overflow pulses, or a rising edge on an external convert-start pin.

Once a start is accepted, the block optionally runs a tracking phase. It then performs one bit decision per SAR clock, most significant bit first. Each decision is driven by a 1-bit comparator answer to a trial code that the block presents. When the last bit is decided, the result is latched and the conversion-complete flag is raised. That flag stays set until software clears it.

The SAR clock is a clock-enable pulse derived from the system clock by a divide ratio supplied on an input.

Top module: `adc_start_seq`

## Requirements
- R1: After reset the control register reads 0x00 and busy is 0. The register layout is: bit 7 enable, bit 6 track style, bit 5 conversion-complete flag, bit 4 busy (read-only status), bits 3:2 start mode, bit 1 window flag, bit 0 justify select. Bits 7, 6, 5, 3:2, 1 and 0 are read/write.
- R2: While enable is 0, no start source begins a conversion and the track output is 0. A write that clears enable in the middle of a sequence counts as disabled in that same cycle.
- R3: Start mode 00 begins a conversion when a register write carries 1 in bit 4. Writing 0 there has no effect. Writing 1 there while the start mode is not 00 starts nothing. Every decision made in a write cycle uses the value being written.
- R4: Start mode 01 starts on a pulse of the first timer input (`tmr_a_ovf`). Mode 11 starts on a pulse of the second timer input (`tmr_b_ovf`). Mode 10 starts on a rising edge of the convert-start pin. Sources that the mode does not select are ignored.
- R5: With track style 0, track is 1 whenever the block is enabled and idle. An accepted start raises busy at the next clock edge.
- R6: With track style 1 and start mode 00, 01 or 11, an accepted start opens a tracking phase of exactly 3 SAR clocks. During that phase track is 1 and busy is 0. Conversion follows the phase.
- R7: With track style 1 and start mode 10, track equals the inverse of the pin while idle. A rising edge of the pin raises busy at the next clock edge, with no tracking phase.
- R8: A conversion takes N SAR clocks (N = 12 by default). Bit N-1 is decided first. A bit is kept when the comparator answers 1 to the trial code on `dac_code`. The final code appears on `result` at the edge where busy falls, and `result` does not change otherwise.
- R9: The conversion-complete flag is set at the edge where busy falls after a completed conversion. Hardware never clears it. A software write of 0 clears it. If the set and a software write land in the same cycle, the set wins.
- R10: A start event arriving during a tracking phase or while busy is 1 is ignored. The running sequence keeps its length.
- R11: A SAR clock occurs every `div_sel`+1 system clocks, counted from the accepting edge.
- R12: Disabling during tracking or conversion returns the block to idle at once. The complete flag is not set and `result` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| tmr_a_ovf | input | 1 | Single-cycle overflow pulse, start source for mode 01 |
| tmr_b_ovf | input | 1 | Single-cycle overflow pulse, start source for mode 11 |
| cnv_pin | input | 1 | External convert-start pin |
| cmp_in | input | 1 | Comparator answer: analog input is at or above `dac_code` |
| div_sel | input | DIVW | SAR clock divide ratio minus one |
| rd_data | output | 8 | Control register read value |
| busy | output | 1 | Conversion in progress |
| track | output | 1 | Sampling front end should track |
| dac_code | output | N | Trial code during conversion, 0 otherwise |
| result | output | N | Last completed conversion code |

## Verification
Two events can fall into the same cycle, and the bench provokes both.

The first pairing is the final bit decision, which sets the complete flag, and a software write that clears that flag. The bench holds off until its own reference model reports that the next edge ends the conversion, then writes 0 to the flag in exactly that cycle. It passes only if the flag reads 1 afterwards.

The second pairing is a start event and a running sequence. Timer pulses are fired in the middle of the tracking phase and in the middle of conversion. The bench passes only if the phase lengths, measured in cycles, are unchanged and a single completion results.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_TRACK = 2'b01,
    ST_CONV  = 2'b10
  } seq_st_e;

  typedef enum logic [1:0] {
    SM_SOFT = 2'b00,
    SM_TMRA = 2'b01,
    SM_PIN  = 2'b10,
    SM_TMRB = 2'b11
  } start_mode_e;

  localparam int B_EN    = 7;
  localparam int B_TRK   = 6;
  localparam int B_DONE  = 5;
  localparam int B_BUSY  = 4;
  localparam int B_MODE  = 2;
  localparam int B_WIN   = 1;
  localparam int B_JUST  = 0;

  localparam int TRACK_TICKS = 3;

endpackage

// File: rtl/adc_sar_tick.sv
module adc_sar_tick #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q >= div);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  start_mode_e mode,
  input  logic        sw_go,
  input  logic        tmr_a,
  input  logic        tmr_b,
  input  logic        pin,
  output logic        trig
);

  logic pin_q;
  logic pin_rise;
  logic sel;

  assign pin_rise = pin && !pin_q;

  always_comb begin
    case (mode)
      SM_SOFT: sel = sw_go;
      SM_TMRA: sel = tmr_a;
      SM_PIN:  sel = pin_rise;
      SM_TMRB: sel = tmr_b;
      default: sel = 1'b0;
    endcase
  end

  assign trig = en && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin;
    end
  end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         trk_style,
  input  start_mode_e  mode,
  input  logic         trig,
  input  logic         tick,
  input  logic         cmp,
  output logic         accept,
  output logic         busy,
  output logic         tracking,
  output logic         done,
  output logic [N-1:0] dac,
  output logic [N-1:0] result
);

  localparam int            TCW     = $clog2(TRACK_TICKS);
  localparam logic [TCW-1:0] TC_LAST = TCW'(TRACK_TICKS - 1);
  localparam logic [N-1:0]  MSB     = {1'b1, {(N-1){1'b0}}};

  seq_st_e        st_q, st_d;
  logic [TCW-1:0] tc_q, tc_d;
  logic [N-1:0]   mask_q, mask_d;
  logic [N-1:0]   work_q, work_d;
  logic [N-1:0]   res_q, res_d;
  logic [N-1:0]   decided;

  assign decided = cmp ? (work_q | mask_q) : work_q;

  always_comb begin
    st_d   = st_q;
    tc_d   = tc_q;
    mask_d = mask_q;
    work_d = work_q;
    res_d  = res_q;
    accept = 1'b0;
    done   = 1'b0;
    if (!en) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (trig) begin
            accept = 1'b1;
            st_d   = (trk_style && (mode != SM_PIN)) ? ST_TRACK : ST_CONV;
            tc_d   = '0;
            mask_d = MSB;
            work_d = '0;
          end
        end
        ST_TRACK: begin
          if (tick) begin
            if (tc_q == TC_LAST) begin
              st_d   = ST_CONV;
              mask_d = MSB;
              work_d = '0;
            end else begin
              tc_d = tc_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick) begin
            work_d = decided;
            mask_d = mask_q >> 1;
            if (mask_q[0]) begin
              st_d  = ST_IDLE;
              res_d = decided;
              done  = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tc_q   <= '0;
      mask_q <= '0;
      work_q <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      tc_q   <= tc_d;
      mask_q <= mask_d;
      work_q <= work_d;
      res_q  <= res_d;
    end
  end

  assign busy     = (st_q == ST_CONV);
  assign tracking = (st_q == ST_TRACK);
  assign dac      = busy ? (work_q | mask_q) : '0;
  assign result   = res_q;

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int N    = 12,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            tmr_a_ovf,
  input  logic            tmr_b_ovf,
  input  logic            cnv_pin,
  input  logic            cmp_in,
  input  logic [DIVW-1:0] div_sel,
  output logic [7:0]      rd_data,
  output logic            busy,
  output logic            track,
  output logic [N-1:0]    dac_code,
  output logic [N-1:0]    result
);

  logic [1:0]  rs_q;
  logic        rst_i_n;
  logic [7:0]  ctrl_q, ctrl_d;
  logic [7:0]  cfg;
  start_mode_e mode_eff;
  start_mode_e mode_reg;
  logic        trig;
  logic        tick;
  logic        accept;
  logic        in_track;
  logic        done;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i_n = rs_q[1];

  // decisions in a write cycle follow the value being written
  assign cfg      = wr_en ? wr_data : ctrl_q;
  assign mode_eff = start_mode_e'(cfg[B_MODE +: 2]);
  assign mode_reg = start_mode_e'(ctrl_q[B_MODE +: 2]);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d         = wr_data;
      ctrl_d[B_BUSY] = 1'b0;
    end
    if (done) begin
      ctrl_d[B_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= 8'h00;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  adc_start_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .en     (cfg[B_EN]),
    .mode   (mode_eff),
    .sw_go  (wr_en && wr_data[B_BUSY]),
    .tmr_a  (tmr_a_ovf),
    .tmr_b  (tmr_b_ovf),
    .pin    (cnv_pin),
    .trig   (trig)
  );

  adc_sar_tick #(.DIVW(DIVW)) u_tick (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (cfg[B_EN]),
    .restart (accept),
    .div     (div_sel),
    .tick    (tick)
  );

  adc_seq_core #(.N(N)) u_core (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (cfg[B_EN]),
    .trk_style (cfg[B_TRK]),
    .mode      (mode_eff),
    .trig      (trig),
    .tick      (tick),
    .cmp       (cmp_in),
    .accept    (accept),
    .busy      (busy),
    .tracking  (in_track),
    .done      (done),
    .dac       (dac_code),
    .result    (result)
  );

  always_comb begin
    rd_data         = ctrl_q;
    rd_data[B_BUSY] = busy;
  end

  always_comb begin
    track = 1'b0;
    if (ctrl_q[B_EN]) begin
      if (in_track) begin
        track = 1'b1;
      end else if (!busy) begin
        track = ctrl_q[B_TRK] ? ((mode_reg == SM_PIN) && !cnv_pin) : 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [7:0]   rd_data,
  input logic         busy,
  input logic         track,
  input logic [N-1:0] result
);

  a_r2_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[7] && !wr_en) |=> (!busy && !track));

  a_r9_flag_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && rd_data[7]) |-> rd_data[5]);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && !wr_en) |=> rd_data[5]);

  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(result));

  a_r6_track_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && track));

  a_r1_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] == busy);

endmodule

bind adc_start_seq adc_start_seq_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .busy    (busy),
  .track   (track),
  .result  (result)
);

// File: tb/tb_adc_start_seq.sv
`timescale 1ns/1ps
module tb_adc_start_seq;

  localparam int N    = 12;
  localparam int DIVW = 4;

  logic            clk;
  logic            rst_n;
  logic            wr_en;
  logic [7:0]      wr_data;
  logic            tmr_a_ovf;
  logic            tmr_b_ovf;
  logic            cnv_pin;
  logic            cmp_in;
  logic [DIVW-1:0] div_sel;
  logic [7:0]      rd_data;
  logic            busy;
  logic            track;
  logic [N-1:0]    dac_code;
  logic [N-1:0]    result;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit finished = 0;
  int vin = 0;

  adc_start_seq #(.N(N), .DIVW(DIVW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf), .cnv_pin(cnv_pin),
    .cmp_in(cmp_in), .div_sel(div_sel), .rd_data(rd_data), .busy(busy),
    .track(track), .dac_code(dac_code), .result(result)
  );

  assign cmp_in = (vin >= int'(dac_code));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_ctrl, m_st, m_cnt, m_tc, m_mask, m_work, m_res, m_pinq, m_rs;

  task automatic m_clear();
    m_ctrl = 0; m_st = 0; m_cnt = 0; m_tc = 0;
    m_mask = 0; m_work = 0; m_res = 0; m_pinq = 0;
  endtask

  always @(posedge clk) begin
    int cfg, mode, ncnt;
    bit en, tm, rise, go, tk, fin;
    if (!rst_n) begin
      m_rs = 0;
      m_clear();
    end else if (m_rs < 2) begin
      m_rs++;
      m_clear();
    end else begin
      cfg  = wr_en ? int'(wr_data) : m_ctrl;
      en   = cfg[7];
      tm   = cfg[6];
      mode = (cfg >> 2) & 3;
      rise = cnv_pin && (m_pinq == 0);
      case (mode)
        0: go = wr_en && wr_data[4];
        1: go = tmr_a_ovf;
        2: go = rise;
        default: go = tmr_b_ovf;
      endcase
      go  = go && en;
      tk  = en && (m_cnt >= int'(div_sel));
      fin = 0;
      if (!en) begin
        m_st = 0;
        ncnt = 0;
      end else if (m_st == 0 && go) begin
        m_st = (tm && mode != 2) ? 1 : 2;
        m_tc = 0; m_mask = 1 << (N-1); m_work = 0;
        ncnt = 0;
      end else begin
        ncnt = tk ? 0 : (m_cnt + 1) % (1 << DIVW);
        if (m_st == 1 && tk) begin
          if (m_tc == 2) begin
            m_st = 2; m_mask = 1 << (N-1); m_work = 0;
          end else m_tc++;
        end else if (m_st == 2 && tk) begin
          if (vin >= (m_work | m_mask)) m_work = m_work | m_mask;
          if (m_mask == 1) begin
            m_res = m_work; m_st = 0; fin = 1;
          end
          m_mask = m_mask >> 1;
        end
      end
      m_cnt  = ncnt;
      m_pinq = cnv_pin;
      if (wr_en) m_ctrl = int'(wr_data) & 'hEF;
      if (fin) m_ctrl = m_ctrl | 'h20;
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    int e_rd, e_dac;
    bit e_busy, e_trk;
    if (cmp_on && !finished) begin
      e_busy = (m_st == 2);
      e_rd   = m_ctrl | (e_busy ? 'h10 : 0);
      e_dac  = e_busy ? (m_work | m_mask) : 0;
      e_trk  = 0;
      if (m_ctrl[7]) begin
        if (m_st == 1) e_trk = 1;
        else if (m_st == 0)
          e_trk = m_ctrl[6] ? ((((m_ctrl >> 2) & 3) == 2) && !cnv_pin) : 1'b1;
      end
      checks++;
      if (int'(rd_data) != e_rd) begin
        fails++; $display("FAIL R1 model rd_data act=%h exp=%h", rd_data, e_rd);
      end
      checks++;
      if (busy != e_busy) begin
        fails++; $display("FAIL R8 model busy act=%0b exp=%0b", busy, e_busy);
      end
      checks++;
      if (track != e_trk) begin
        fails++; $display("FAIL R5 model track act=%0b exp=%0b", track, e_trk);
      end
      checks++;
      if (int'(dac_code) != e_dac) begin
        fails++; $display("FAIL R8 model dac_code act=%h exp=%h", dac_code, e_dac);
      end
      checks++;
      if (int'(result) != m_res) begin
        fails++; $display("FAIL R8 model result act=%h exp=%h", result, m_res);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_a();
    tmr_a_ovf = 1'b1; step(); tmr_a_ovf = 1'b0;
  endtask

  task automatic pulse_b();
    tmr_b_ovf = 1'b1; step(); tmr_b_ovf = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0; cnv_pin = 1'b0; div_sel = 4'd1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    cmp_on = 1;

    chk("R1 reset rd_data", int'(rd_data), 'h00);
    chk("R1 reset busy", int'(busy), 0);
    wr(8'h03);
    chk("R1 low bits read back", int'(rd_data), 'h03);

    // software start, track style 0
    vin = 'hA5C;
    wr(8'h80);
    chk("R5 track while idle", int'(track), 1);
    wr(8'h90);
    chk("R5 R3 busy after write of 1", int'(busy), 1);
    n = 0;
    while (busy) begin n++; step(); end
    chk("R8 R11 conversion length div=1", n, 24);
    chk("R8 result code", int'(result), 'hA5C);
    chk("R9 flag set at end", int'(rd_data), 'hA0);
    repeat (3) step();
    chk("R9 flag sticky", int'(rd_data[5]), 1);
    wr(8'h80);
    chk("R9 flag cleared by write", int'(rd_data), 'h80);

    // busy bit with non-zero mode
    wr(8'h94);
    chk("R3 busy write ignored in mode 01", int'(busy), 0);
    chk("R3 register after write", int'(rd_data), 'h84);
    wr(8'h84);
    chk("R3 write of 0 no effect", int'(busy), 0);

    // timer starts, mode 01
    vin = 'h123;
    pulse_b();
    chk("R4 unselected timer ignored", int'(busy), 0);
    pulse_a();
    chk("R4 selected timer starts", int'(busy), 1);
    n = 1;
    while (busy) begin
      if (n == 5) pulse_a(); else step();
      n++;
    end
    chk("R10 retrigger while busy ignored", n - 1, 24);
    repeat (3) step();
    chk("R10 no second conversion", int'(busy), 0);
    chk("R8 result after timer start", int'(result), 'h123);

    // divider 3
    div_sel = 4'd3;
    vin = 'h3C1;
    wr(8'h80);
    wr(8'h90);
    n = 0;
    while (busy) begin n++; step(); end
    chk("R11 conversion length div=3", n, 48);
    chk("R8 result div=3", int'(result), 'h3C1);

    // track style 1, mode 11
    div_sel = 4'd1;
    vin = 'hFFF;
    wr(8'hCC);
    chk("R6 no tracking while idle", int'(track), 0);
    pulse_b();
    chk("R6 tracking after trigger", int'(track), 1);
    chk("R6 not busy while tracking", int'(busy), 0);
    n = 1;
    while (track) begin
      if (n == 2) pulse_b(); else step();
      n++;
    end
    chk("R6 R10 track phase length", n - 1, 6);
    chk("R6 conversion follows track", int'(busy), 1);
    n = 0;
    while (busy) begin n++; step(); end
    chk("R10 conversion length after track", n, 24);
    chk("R8 full-scale result", int'(result), 'hFFF);

    // track style 1, pin mode
    vin = 0;
    wr(8'hE8);
    wr(8'hC8);
    chk("R7 tracks while pin low", int'(track), 1);
    cnv_pin = 1'b1;
    #1;
    chk("R7 track drops with pin high", int'(track), 0);
    step();
    chk("R7 rising edge starts conversion", int'(busy), 1);
    wait_idle();
    chk("R8 zero result", int'(result), 0);
    cnv_pin = 1'b0;
    step();

    // track style 0, pin mode
    vin = 'h055;
    wr(8'h88);
    cnv_pin = 1'b1;
    step();
    chk("R4 pin rising edge starts", int'(busy), 1);
    wait_idle();
    cnv_pin = 1'b0;
    step();
    chk("R4 pin mode result", int'(result), 'h055);

    // disabled
    wr(8'h0C);
    chk("R2 no tracking when disabled", int'(track), 0);
    pulse_b();
    chk("R2 timer ignored when disabled", int'(busy), 0);
    wr(8'h10);
    chk("R2 software start ignored", int'(busy), 0);
    chk("R2 register disabled", int'(rd_data), 'h00);

    // abort
    vin = 1234;
    wr(8'h80);
    wr(8'h90);
    repeat (8) step();
    wr(8'h00);
    chk("R12 busy cleared on disable", int'(busy), 0);
    chk("R12 no flag on abort", int'(rd_data), 'h00);
    chk("R12 result unchanged", int'(result), 'h055);
    repeat (30) step();
    chk("R12 flag stays clear", int'(rd_data[5]), 0);

    // set versus clear in the same cycle
    vin = 'h777;
    wr(8'h80);
    wr(8'h90);
    while (!(m_st == 2 && m_mask == 1 && m_cnt >= int'(div_sel))) step();
    wr(8'h80);
    chk("R9 hardware set wins", int'(rd_data), 'hA0);
    chk("R9 result at priority case", int'(result), 'h777);

    repeat (3) step();
    finish_run();
  end

endmodule